// File: doc/BRIEF.md
# Receive Pool Assignment Filter

This block decides which receive queues get a copy of an incoming frame when the receiver shares the link among eight virtual pools. Each frame is presented for one cycle with an input strobe. The block takes the frame's destination address, its length and a few flags that neighbouring logic has already worked out: broadcast, VLAN-tagged, which pools matched the exact unicast address, and whether the multicast hash table hit. It also sees each pool's configuration. From these it produces a 16-bit queue bitmap. Bits 0 to 7 are the base queue of each pool, and bits 8 to 15 are the second queue of each pool, used when the receive-side hash picks it.

The block computes the multicast hash table coordinates from the destination address and drives them out. The external table returns its hit flag within the same cycle. Candidate pools are then chosen by frame class, with a fallback to a default pool. The result is masked by the per-pool receive enables and trimmed by a per-pool length limit. Finally it is spread onto upper queues by the hash result bit. The bitmap is registered, and an all-zero bitmap means the frame is dropped. A one-cycle pulse tells the statistics logic to count an oversize frame whenever every enabled candidate pool rejected the frame for length.

Top module: `rx_pool_filter`

## Requirements
- R1: A frame with `is_bcast` high selects exactly the pools whose bit in `pool_bcast_acc` is 1 (before default, enable, length and hash steps).
- R2: The hash index is the 16-bit value {dst_mac[7:0], dst_mac[15:8]} shifted right by 4, 3, 2 or 0 for `mc_offset` = 0, 1, 2, 3, keeping the low 12 bits. `mc_word` carries index bits [11:5] and `mc_bit` carries bits [4:0], combinationally.
- R3: A non-broadcast frame whose group bit `dst_mac[40]` is 1 selects the pools set in `pool_mcast_acc` when `mc_hash_hit` is 1, and no pool when it is 0.
- R4: A non-broadcast frame with `dst_mac[40]` at 0 selects the pools in `uc_pool_hit`. If `is_tagged` is 0, the selection is further limited to pools set in `pool_untag_acc`.
- R5: When the steps of R1 to R4 select no pool, the single pool numbered `def_pool` is selected.
- R6: The selection is ANDed with `vf_rx_en`; a pool whose enable bit is 0 never receives the frame.
- R7: Pool i rejects the frame when `frame_len` exceeds its 14-bit limit in `pool_max_len[14*i +: 14]`, if `pool_big_en[i]` is 1. Otherwise it rejects the frame when `frame_len` exceeds 1522. A rejecting pool is removed, so length 1522 passes a standard pool and 1523 does not.
- R8: `oversize_inc` pulses for one cycle when at least one pool is left after R6 and every one of them rejects the frame under R7.
- R9: When `rss_odd` is 1, each surviving pool i with `pool_rss_en[i]` = 1 appears at bit i+8 of `out_queues` instead of bit i. Otherwise pool i appears at bit i.
- R10: `out_valid`, `out_queues` and `oversize_inc` reflect the input of the previous cycle's strobe. Without a strobe they are 0, and all are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame descriptor strobe |
| dst_mac | input | 48 | Destination address, first byte in [47:40] |
| frame_len | input | 14 | Frame length in bytes |
| is_bcast | input | 1 | Frame is broadcast |
| is_tagged | input | 1 | Frame carries a VLAN tag |
| uc_pool_hit | input | 8 | Pools whose exact unicast address matched |
| mc_offset | input | 2 | Hash bit-offset selector |
| mc_word | output | 7 | Hash table word index |
| mc_bit | output | 5 | Bit within the hash table word |
| mc_hash_hit | input | 1 | Hash table bit value returned for the index |
| def_pool | input | 3 | Default pool number |
| pool_bcast_acc | input | 8 | Per-pool broadcast accept |
| pool_mcast_acc | input | 8 | Per-pool multicast-hash accept |
| pool_untag_acc | input | 8 | Per-pool untagged accept |
| pool_big_en | input | 8 | Per-pool large-frame enable |
| pool_rss_en | input | 8 | Per-pool upper-queue spreading enable |
| pool_max_len | input | 112 | Per-pool length limit, 14 bits each |
| vf_rx_en | input | 8 | Per-pool receive enable |
| rss_odd | input | 1 | Receive hash selected the second queue |
| out_valid | output | 1 | Result valid |
| out_queues | output | 16 | Destination queue bitmap, zero means drop |
| oversize_inc | output | 1 | Oversize counter increment pulse |

## Verification
The oversize pulse and the queue bitmap are produced in the same cycle. In one corner case the default-pool fallback and the length check meet: no pool is selected, the default pool is enabled, and the frame is too long for it. The pulse must rise while the bitmap is zero. The bench forces this with directed frames of length 1522 and 1523 against a standard-limit default pool. It also mixes in random frames whose lengths and limits straddle each other. Each cycle's pulse and bitmap are compared together against a bench model. That model also covers the case where the receive enable removes every candidate, which must give a zero bitmap with no pulse.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
    localparam int NPOOL    = 8;
    localparam int LEN_W    = 14;
    localparam int HASH_W   = 12;
    localparam int STD_MAX  = 1522;

    // Hash index from the two last address bytes and the offset selector
    function automatic logic [HASH_W-1:0] hash_index(input logic [47:0] dst,
                                                     input logic [1:0] ofs);
        logic [15:0] w;
        logic [15:0] s;
        w = {dst[7:0], dst[15:8]};
        case (ofs)
            2'd0:    s = w >> 4;
            2'd1:    s = w >> 3;
            2'd2:    s = w >> 2;
            default: s = w;
        endcase
        return s[HASH_W-1:0];
    endfunction

    function automatic logic too_long(input logic [LEN_W-1:0] len,
                                      input logic big,
                                      input logic [LEN_W-1:0] lim);
        if (big) return len > lim;
        return len > LEN_W'(STD_MAX);
    endfunction

    typedef struct packed {
        logic [2*NPOOL-1:0] queues;
        logic               ovs;
    } rpf_result_t;
endpackage

// File: rtl/rpf_candidate.sv
module rpf_candidate #(
    parameter int NPOOL = rpf_pkg::NPOOL,
    localparam int PW   = $clog2(NPOOL)
) (
    input  logic             is_bcast,
    input  logic             is_group,
    input  logic             is_tagged,
    input  logic             hash_hit,
    input  logic [NPOOL-1:0] uc_hit,
    input  logic [PW-1:0]    def_pool,
    input  logic [NPOOL-1:0] bcast_acc,
    input  logic [NPOOL-1:0] mcast_acc,
    input  logic [NPOOL-1:0] untag_acc,
    input  logic [NPOOL-1:0] rx_en,
    output logic [NPOOL-1:0] cand
);
    logic [NPOOL-1:0] by_class;
    logic [NPOOL-1:0] with_def;

    always_comb begin
        if (is_bcast)
            by_class = bcast_acc;
        else if (is_group)
            by_class = hash_hit ? mcast_acc : '0;
        else
            by_class = uc_hit & (is_tagged ? {NPOOL{1'b1}} : untag_acc);
        with_def = (by_class != '0) ? by_class : (NPOOL'(1) << def_pool);
        cand     = with_def & rx_en;
    end
endmodule

// File: rtl/rpf_size_gate.sv
module rpf_size_gate #(
    parameter int NPOOL = rpf_pkg::NPOOL,
    parameter int LEN_W = rpf_pkg::LEN_W
) (
    input  logic [NPOOL-1:0]            cand,
    input  logic [LEN_W-1:0]            frame_len,
    input  logic [NPOOL-1:0]            big_en,
    input  logic [NPOOL*LEN_W-1:0]      max_len,
    output logic [NPOOL-1:0]            keep,
    output logic                        ovs
);
    logic [NPOOL-1:0] reject;

    for (genvar i = 0; i < NPOOL; i++) begin : g_pool
        assign reject[i] = cand[i] &&
            rpf_pkg::too_long(frame_len, big_en[i], max_len[i*LEN_W +: LEN_W]);
    end

    assign keep = cand & ~reject;
    assign ovs  = (cand != '0) && (reject == cand);
endmodule

// File: rtl/rpf_rss_remap.sv
module rpf_rss_remap #(
    parameter int NPOOL = rpf_pkg::NPOOL
) (
    input  logic [NPOOL-1:0]   keep,
    input  logic               rss_odd,
    input  logic [NPOOL-1:0]   rss_en,
    output logic [2*NPOOL-1:0] queues
);
    for (genvar i = 0; i < NPOOL; i++) begin : g_move
        logic mv;
        assign mv               = keep[i] & rss_odd & rss_en[i];
        assign queues[i]        = keep[i] & ~mv;
        assign queues[i+NPOOL]  = mv;
    end
endmodule

// File: rtl/rx_pool_filter.sv
module rx_pool_filter #(
    parameter int NPOOL   = rpf_pkg::NPOOL,
    parameter int LEN_W   = rpf_pkg::LEN_W,
    localparam int PW     = $clog2(NPOOL),
    localparam int QW     = 2 * NPOOL,
    localparam int WORD_W = rpf_pkg::HASH_W - 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [47:0]            dst_mac,
    input  logic [LEN_W-1:0]       frame_len,
    input  logic                   is_bcast,
    input  logic                   is_tagged,
    input  logic [NPOOL-1:0]       uc_pool_hit,
    input  logic [1:0]             mc_offset,
    output logic [WORD_W-1:0]      mc_word,
    output logic [4:0]             mc_bit,
    input  logic                   mc_hash_hit,
    input  logic [PW-1:0]          def_pool,
    input  logic [NPOOL-1:0]       pool_bcast_acc,
    input  logic [NPOOL-1:0]       pool_mcast_acc,
    input  logic [NPOOL-1:0]       pool_untag_acc,
    input  logic [NPOOL-1:0]       pool_big_en,
    input  logic [NPOOL-1:0]       pool_rss_en,
    input  logic [NPOOL*LEN_W-1:0] pool_max_len,
    input  logic [NPOOL-1:0]       vf_rx_en,
    input  logic                   rss_odd,
    output logic                   out_valid,
    output logic [QW-1:0]          out_queues,
    output logic                   oversize_inc
);
    import rpf_pkg::*;

    logic [HASH_W-1:0] hidx;
    logic [NPOOL-1:0]  cand;
    logic [NPOOL-1:0]  keep;
    logic              ovs_c;
    rpf_result_t       nxt;
    rpf_result_t       res_q;
    logic              vld_q;

    // R2: hash table coordinates
    assign hidx    = hash_index(dst_mac, mc_offset);
    assign mc_word = hidx[HASH_W-1:5];
    assign mc_bit  = hidx[4:0];

    rpf_candidate #(.NPOOL(NPOOL)) u_cand (
        .is_bcast  (is_bcast),
        .is_group  (dst_mac[40]),
        .is_tagged (is_tagged),
        .hash_hit  (mc_hash_hit),
        .uc_hit    (uc_pool_hit),
        .def_pool  (def_pool),
        .bcast_acc (pool_bcast_acc),
        .mcast_acc (pool_mcast_acc),
        .untag_acc (pool_untag_acc),
        .rx_en     (vf_rx_en),
        .cand      (cand)
    );

    rpf_size_gate #(.NPOOL(NPOOL), .LEN_W(LEN_W)) u_size (
        .cand      (cand),
        .frame_len (frame_len),
        .big_en    (pool_big_en),
        .max_len   (pool_max_len),
        .keep      (keep),
        .ovs       (ovs_c)
    );

    rpf_rss_remap #(.NPOOL(NPOOL)) u_remap (
        .keep    (keep),
        .rss_odd (rss_odd),
        .rss_en  (pool_rss_en),
        .queues  (nxt.queues)
    );
    assign nxt.ovs = ovs_c;

    // R10: one register stage, cleared when idle
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            res_q <= in_valid ? nxt : '0;
        end
    end

    assign out_valid    = vld_q;
    assign out_queues   = res_q.queues;
    assign oversize_inc = res_q.ovs;

    // R10: a strobe yields a result in the following cycle
    p_strobe_latency_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10: idle cycles carry no queues and no pulse
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_queues == '0 && !oversize_inc));

    // R8: counting an oversize frame implies the frame is dropped
    p_ovs_drops_r8: assert property (@(posedge clk) disable iff (rst)
        oversize_inc |-> out_queues == '0);

    // R9: upper queues only appear when the hash picked the second queue
    p_upper_needs_rss_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_queues[QW-1:NPOOL] != '0) |-> $past(rss_odd));

    // R9: a pool lands on at most one of its two queues
    for (genvar i = 0; i < NPOOL; i++) begin : g_chk
        p_one_queue_per_pool_r9: assert property (@(posedge clk) disable iff (rst)
            !(out_queues[i] && out_queues[i+NPOOL]));
    end

    // R6: a disabled pool never receives the frame
    p_rx_enable_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_queues[NPOOL-1:0] | out_queues[QW-1:NPOOL])
                       & ~$past(vf_rx_en)) == '0);
endmodule

// File: tb/sim_rx_pool_filter.sv
`timescale 1ns/1ps
module sim_rx_pool_filter;
    localparam int NP = 8;
    localparam int LW = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic           in_valid = 0;
    logic [47:0]    dst_mac = '0;
    logic [LW-1:0]  frame_len = '0;
    logic           is_bcast = 0, is_tagged = 0, mc_hash_hit = 0, rss_odd = 0;
    logic [NP-1:0]  uc_pool_hit = '0;
    logic [1:0]     mc_offset = '0;
    logic [6:0]     mc_word;
    logic [4:0]     mc_bit;
    logic [2:0]     def_pool = '0;
    logic [NP-1:0]  pool_bcast_acc = '0, pool_mcast_acc = '0, pool_untag_acc = '0;
    logic [NP-1:0]  pool_big_en = '0, pool_rss_en = '0, vf_rx_en = '0;
    logic [NP*LW-1:0] pool_max_len = '0;
    logic           out_valid, oversize_inc;
    logic [2*NP-1:0] out_queues;

    int n_chk = 0;
    int n_err = 0;

    rx_pool_filter u0 (.*);

    function automatic logic [11:0] ref_hash(input logic [47:0] d, input logic [1:0] o);
        logic [15:0] w;
        int sh;
        w  = {d[7:0], d[15:8]};
        sh = (o == 0) ? 4 : (o == 1) ? 3 : (o == 2) ? 2 : 0;
        return 12'((w >> sh) & 16'hFFF);
    endfunction

    // returns {ovs, queues}
    function automatic logic [16:0] ref_out();
        logic [NP-1:0] c, rej, kp;
        logic [15:0] q;
        logic ov;
        if (is_bcast) c = pool_bcast_acc;
        else if (dst_mac[40]) c = mc_hash_hit ? pool_mcast_acc : '0;
        else c = is_tagged ? uc_pool_hit : (uc_pool_hit & pool_untag_acc);
        if (c == 0) c = NP'(1) << def_pool;
        c = c & vf_rx_en;
        for (int i = 0; i < NP; i++) begin
            int lim;
            lim = pool_big_en[i] ? int'(pool_max_len[i*LW +: LW]) : 1522;
            rej[i] = c[i] && (int'(frame_len) > lim);
        end
        kp = c & ~rej;
        ov = (c != 0) && (rej == c);
        q  = '0;
        for (int i = 0; i < NP; i++) begin
            if (kp[i] && rss_odd && pool_rss_en[i]) q[i+NP] = 1'b1;
            else if (kp[i]) q[i] = 1'b1;
        end
        return {ov, q};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, sample at the next negedge (after one rising edge)
    task automatic run_frame(input string req);
        logic [16:0] e;
        #0.5;
        check({req, " R2 hash"}, {20'd0, mc_word, mc_bit}, {20'd0, ref_hash(dst_mac, mc_offset)});
        e = ref_out();
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check({req, " R10 valid"}, 32'(out_valid), 32'd1);
        check({req, " queues"}, 32'(out_queues), 32'(e[15:0]));
        check({req, " R8 pulse"}, 32'(oversize_inc), 32'(e[16]));
    endtask

    task automatic set_all_lim(input int v);
        for (int i = 0; i < NP; i++) pool_max_len[i*LW +: LW] = LW'(v);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R10 reset valid", 32'(out_valid), 32'd0);
        check("R10 reset queues", 32'(out_queues), 32'd0);
        check("R10 reset pulse", 32'(oversize_inc), 32'd0);

        vf_rx_en = 8'hFF; frame_len = 14'd100; set_all_lim(1000);

        // R1 broadcast
        is_bcast = 1; pool_bcast_acc = 8'hA5; dst_mac = 48'hFFFF_FFFF_FFFF;
        run_frame("R1 bcast");
        check("R1 bcast pools", 32'(out_queues), 32'h00A5);
        is_bcast = 0;

        // R3 multicast hit and miss
        dst_mac = 48'h0100_5E00_1234; pool_mcast_acc = 8'h3C; def_pool = 3'd6;
        mc_hash_hit = 1; run_frame("R3 mc hit");
        check("R3 mc hit pools", 32'(out_queues), 32'h003C);
        mc_hash_hit = 0; run_frame("R3 mc miss");
        check("R5 mc miss to default", 32'(out_queues), 32'h0040);

        // R4 unicast tagged and untagged
        dst_mac = 48'h0022_3344_5566; uc_pool_hit = 8'h0F; pool_untag_acc = 8'h05;
        is_tagged = 1; run_frame("R4 uc tagged");
        check("R4 uc tagged pools", 32'(out_queues), 32'h000F);
        is_tagged = 0; run_frame("R4 uc untagged");
        check("R4 uc untagged pools", 32'(out_queues), 32'h0005);

        // R5 default, R6 default disabled
        uc_pool_hit = '0; def_pool = 3'd2; run_frame("R5 default");
        check("R5 default pool", 32'(out_queues), 32'h0004);
        vf_rx_en = 8'hFB; run_frame("R6 default disabled");
        check("R6 disabled no pulse", 32'({oversize_inc, out_queues}), 32'h0);
        vf_rx_en = 8'hFF;

        // R7/R8 standard limit boundary with default pool
        frame_len = 14'd1522; run_frame("R7 len 1522");
        check("R7 1522 passes", 32'(out_queues), 32'h0004);
        frame_len = 14'd1523; run_frame("R7 len 1523");
        check("R8 1523 dropped+pulse", 32'({oversize_inc, out_queues}), 32'h10000);

        // R7 large-frame limit, partial rejection gives no pulse
        is_bcast = 1; pool_bcast_acc = 8'h03; pool_big_en = 8'h01; set_all_lim(2000);
        frame_len = 14'd1600; run_frame("R7 big limit");
        check("R8 partial no pulse", 32'({oversize_inc, out_queues}), 32'h0001);
        is_bcast = 0; pool_big_en = '0; frame_len = 14'd64;

        // R9 spreading
        is_tagged = 1; uc_pool_hit = 8'hF0; pool_rss_en = 8'h50; rss_odd = 1;
        run_frame("R9 rss odd");
        check("R9 moved pools", 32'(out_queues), 32'h50A0);
        rss_odd = 0; run_frame("R9 rss even");
        check("R9 unmoved", 32'(out_queues), 32'h00F0);

        // R10 idle cycle after a frame
        @(negedge clk);
        check("R10 idle", 32'({out_valid, oversize_inc, out_queues}), 32'h0);

        // random mix
        for (int k = 0; k < 400; k++) begin
            dst_mac        = {$urandom, $urandom};
            is_bcast       = ($urandom_range(0, 4) == 0);
            is_tagged      = $urandom_range(0, 1);
            uc_pool_hit    = NP'($urandom);
            mc_offset      = 2'($urandom);
            mc_hash_hit    = $urandom_range(0, 1);
            def_pool       = 3'($urandom);
            pool_bcast_acc = NP'($urandom);
            pool_mcast_acc = NP'($urandom);
            pool_untag_acc = NP'($urandom);
            pool_big_en    = NP'($urandom);
            pool_rss_en    = NP'($urandom);
            vf_rx_en       = NP'($urandom);
            rss_odd        = $urandom_range(0, 1);
            frame_len      = LW'($urandom_range(1400, 1700));
            for (int i = 0; i < NP; i++)
                pool_max_len[i*LW +: LW] = LW'($urandom_range(1400, 1700));
            run_frame("R7 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule